// File: doc/BRIEF.md
# UART Interrupt Arbiter and Identifier

This block chooses which interrupt a 16550-style UART reports and presents the identification byte that the host reads. It combines several inputs. The interrupt enable nibble and the receive FIFO count against its trigger level are two of them. The others are a character-timeout flag, the receive error conditions, a transmitter-empty event and four modem-line change events. From these it produces a registered identification byte and an interrupt request line. The bus decoder, the FIFOs and the shift registers sit outside the block. They reach it only as level flags, event pulses and read or write selects.

The block also owns the pending state that register reads consume. Reading the identification register clears a pending transmitter-empty interrupt, but only when that read returned the transmitter-empty code. A read of the line status register drops the sticky overrun and break flags. A read of the modem status register drops the four change flags. Each read select is edge-detected inside the block, so a select held for many cycles acts only once. All interfaces are plain control and status pins. The block carries no data stream, so it has no valid/ready handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, iir_value is 0x01, irq is 0, ier_value is 0x00, and both line_err and msr_delta are 0.
- R2: The low nibble of iir_value holds the code of the highest pending enabled source. In priority order: line error 0x6, enabled by IER bit 2, pending when overrun, parity, framing or break is set. Timeout 0xC. Receive data 0x4, enabled by bit 0. Transmitter empty 0x2, enabled by bit 1. Modem change 0x0, enabled by bit 3, pending when any msr_delta bit is set. With nothing pending the code is 0x1.
- R3: The character-timeout source is taken only when IER bit 0 is set; it has no enable of its own.
- R4: Receive data is pending when rx_ready is high and either fifo_en is low or rx_count is at least the trigger level. The trigger level is 1, 4, 8 or 14 for rx_trig 0, 1, 2 or 3.
- R5: iir_value bits 7:6 are 11 when fifo_en was high in the previous cycle and 00 otherwise; bits 5:4 are 0. These upper bits do not depend on which code is selected.
- R6: iir_value and irq take their new values at the first clock edge after an input change; irq is high exactly when the code is not 0x1.
- R7: A rising read of the identification register while it shows code 0x2 clears the transmitter-empty pending flag. A read showing any other code leaves that flag set.
- R8: An IER write stores ier_wdata bits 3:0 (ier_value bits 7:4 read 0). If tx_empty is high during the write, the transmitter-empty pending flag is set.
- R9: A rising read of line status clears line_err bit 0 (overrun) and bit 3 (break). Bit 1 (parity) and bit 2 (framing) follow rx_par_err and rx_frm_err and are not touched by the read.
- R10: A rising read of modem status clears all four msr_delta bits.
- R11: A read select held high for several cycles counts as one read, at its first cycle; events arriving while it stays high are kept.
- R12: An event that sets a flag in the same cycle as a clearing read or thr_wr wins, and the flag stays set.
- R13: tx_done sets the transmitter-empty pending flag; thr_wr clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enabled |
| ier_wr | input | 1 | Interrupt enable write strobe |
| ier_wdata | input | 8 | Interrupt enable write data |
| rd_iir | input | 1 | Identification register read select |
| rd_lsr | input | 1 | Line status read select |
| rd_msr | input | 1 | Modem status read select |
| rx_ready | input | 1 | Received data present |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | 2 | Receive trigger level select |
| rx_timeout | input | 1 | Character timeout pending |
| rx_par_err | input | 1 | Parity error on head character |
| rx_frm_err | input | 1 | Framing error on head character |
| ev_overrun | input | 1 | Receive overrun event pulse |
| ev_break | input | 1 | Break detected event pulse |
| tx_empty | input | 1 | Transmit holding register empty (level) |
| tx_done | input | 1 | Transmit holding register became empty (pulse) |
| thr_wr | input | 1 | Transmit holding register written |
| ev_msr_delta | input | 4 | Modem line change event pulses |
| ier_value | output | 8 | Current interrupt enable register |
| iir_value | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |
| line_err | output | 4 | {break, framing, parity, overrun} |
| msr_delta | output | 4 | Sticky modem change flags |

## Verification
The bench probes each trigger level one count below and at its threshold. An off-by-one compare would raise receive data a byte early or late. It pairs timeout with a cleared IER bit 0 to catch a design that gives timeout its own enable. It reads the identification register while a higher code masks a pending transmitter-empty interrupt, and a design that cleared on any read would then lose that interrupt. Held read selects, and event pulses that land in the same cycle as a clearing read, expose missing edge detection (repeated clears) or a wrong set/clear precedence (lost events).

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  // index 0 is the highest priority
  localparam int NSRC = 5;

  typedef struct packed {
    logic modem;
    logic thre;
    logic rxdata;
    logic timeout;
    logic line;
  } src_req_t;

  function automatic logic [3:0] code_of(input int idx);
    case (idx)
      0:       code_of = IID_LINE;
      1:       code_of = IID_TIMEOUT;
      2:       code_of = IID_RXDATA;
      3:       code_of = IID_THRE;
      default: code_of = IID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic          rx_ready,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    rx_trig,
  output logic          rx_avail
);

  function automatic logic [CW-1:0] level_of(input logic [1:0] sel);
    case (sel)
      2'd0:    level_of = CW'(1);
      2'd1:    level_of = CW'(DEPTH / 4);
      2'd2:    level_of = CW'(DEPTH / 2);
      default: level_of = CW'(DEPTH - 2);
    endcase
  endfunction

  logic [CW-1:0] thresh;

  always_comb begin
    thresh   = level_of(rx_trig);
    rx_avail = rx_ready && (!fifo_en || (rx_count >= thresh));
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_req_t    req,
  output logic [3:0]  code
);

  logic [NSRC-1:0] req_vec;

  always_comb begin
    req_vec = {req.modem, req.thre, req.rxdata, req.timeout, req.line};
    code    = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_vec[i]) code = code_of(i);
    end
  end

endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state
  import uart_irq_pkg::*;
#(
  parameter int IER_W  = 4,
  parameter int MSR_DW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [IER_W-1:0]  ier_wbits,
  input  logic              tx_empty,
  input  logic              tx_done,
  input  logic              thr_wr,
  input  logic              rd_iir,
  input  logic              rd_lsr,
  input  logic              rd_msr,
  input  logic [3:0]        iir_code,
  input  logic              ev_overrun,
  input  logic              ev_break,
  input  logic [MSR_DW-1:0] ev_msr_delta,
  output logic [IER_W-1:0]  ier_q,
  output logic              thre_pend,
  output logic              oe_q,
  output logic              bi_q,
  output logic [MSR_DW-1:0] msr_d
);

  localparam int NRD = 3;

  logic [NRD-1:0] rd_lvl, rd_prev, rd_hit;
  logic           thre_set, thre_clr;

  always_comb begin
    rd_lvl   = {rd_msr, rd_lsr, rd_iir};
    rd_hit   = rd_lvl & ~rd_prev;
    thre_set = tx_done || (ier_wr && tx_empty);
    thre_clr = thr_wr || (rd_hit[0] && (iir_code == IID_THRE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= '0;
      ier_q     <= '0;
      thre_pend <= 1'b0;
      oe_q      <= 1'b0;
      bi_q      <= 1'b0;
    end else begin
      rd_prev <= rd_lvl;
      if (ier_wr) ier_q <= ier_wbits;
      if (thre_set)      thre_pend <= 1'b1;
      else if (thre_clr) thre_pend <= 1'b0;
      if (ev_overrun)     oe_q <= 1'b1;
      else if (rd_hit[1]) oe_q <= 1'b0;
      if (ev_break)       bi_q <= 1'b1;
      else if (rd_hit[1]) bi_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < MSR_DW; g++) begin : g_delta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               msr_d[g] <= 1'b0;
      else if (ev_msr_delta[g]) msr_d[g] <= 1'b1;
      else if (rd_hit[2])       msr_d[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int IER_W  = 4,
  parameter int MSR_DW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              ier_wr,
  input  logic [7:0]        ier_wdata,
  input  logic              rd_iir,
  input  logic              rd_lsr,
  input  logic              rd_msr,
  input  logic              rx_ready,
  input  logic [CW-1:0]     rx_count,
  input  logic [1:0]        rx_trig,
  input  logic              rx_timeout,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              ev_overrun,
  input  logic              ev_break,
  input  logic              tx_empty,
  input  logic              tx_done,
  input  logic              thr_wr,
  input  logic [MSR_DW-1:0] ev_msr_delta,
  output logic [7:0]        ier_value,
  output logic [7:0]        iir_value,
  output logic              irq,
  output logic [3:0]        line_err,
  output logic [MSR_DW-1:0] msr_delta
);

  logic [IER_W-1:0] ier_q;
  logic             thre_pend, oe_q, bi_q, rx_avail;
  logic [3:0]       next_code;
  logic [7:0]       iir_q;
  src_req_t         req;
  logic             unused_ier_hi;

  assign unused_ier_hi = ^ier_wdata[7:IER_W];

  uart_irq_state #(.IER_W(IER_W), .MSR_DW(MSR_DW)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .ier_wr       (ier_wr),
    .ier_wbits    (ier_wdata[IER_W-1:0]),
    .tx_empty     (tx_empty),
    .tx_done      (tx_done),
    .thr_wr       (thr_wr),
    .rd_iir       (rd_iir),
    .rd_lsr       (rd_lsr),
    .rd_msr       (rd_msr),
    .iir_code     (iir_q[3:0]),
    .ev_overrun   (ev_overrun),
    .ev_break     (ev_break),
    .ev_msr_delta (ev_msr_delta),
    .ier_q        (ier_q),
    .thre_pend    (thre_pend),
    .oe_q         (oe_q),
    .bi_q         (bi_q),
    .msr_d        (msr_delta)
  );

  uart_irq_trig #(.DEPTH(DEPTH), .CW(CW)) u_trig (
    .fifo_en  (fifo_en),
    .rx_ready (rx_ready),
    .rx_count (rx_count),
    .rx_trig  (rx_trig),
    .rx_avail (rx_avail)
  );

  always_comb begin
    req.line    = ier_q[2] && (oe_q || bi_q || rx_par_err || rx_frm_err);
    req.timeout = ier_q[0] && rx_timeout;
    req.rxdata  = ier_q[0] && rx_avail;
    req.thre    = ier_q[1] && thre_pend;
    req.modem   = ier_q[3] && (|msr_delta);
  end

  uart_irq_prio u_prio (
    .req  (req),
    .code (next_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iir_q <= {4'h0, IID_NONE};
    else        iir_q <= {fifo_en, fifo_en, 2'b00, next_code};
  end

  always_comb begin
    iir_value = iir_q;
    irq       = (iir_q[3:0] != IID_NONE);
    ier_value = {{(8 - IER_W){1'b0}}, ier_q};
    line_err  = {bi_q, rx_frm_err, rx_par_err, oe_q};
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic       rd_lsr,
  input logic       rd_msr,
  input logic       ev_overrun,
  input logic       ev_break,
  input logic [3:0] ev_msr_delta,
  input logic [7:0] ier_value,
  input logic [7:0] iir_value,
  input logic [3:0] line_err,
  input logic [3:0] msr_delta
);

  AST_FIFO_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (iir_value[7:6] == {2{$past(fifo_en)}})); // R5

  AST_IER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_value == {4'h0, $past(ier_wdata[3:0])})); // R8

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    iir_value[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC}); // R2

  AST_TIMEOUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && iir_value[3:0] == 4'hC) |-> $past(ier_value[0])); // R3

  AST_LINE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && iir_value[3:0] == 4'h6) |-> $past(ier_value[2] && (line_err != 4'h0))); // R2

  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_lsr) && !ev_overrun && !ev_break) |=> (!line_err[0] && !line_err[3])); // R9

  AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_msr) && ev_msr_delta == 4'h0) |=> (msr_delta == 4'h0)); // R10

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .ier_wr       (ier_wr),
  .ier_wdata    (ier_wdata),
  .rd_lsr       (rd_lsr),
  .rd_msr       (rd_msr),
  .ev_overrun   (ev_overrun),
  .ev_break     (ev_break),
  .ev_msr_delta (ev_msr_delta),
  .ier_value    (ier_value),
  .iir_value    (iir_value),
  .line_err     (line_err),
  .msr_delta    (msr_delta)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int CW = 5;
  localparam int NV = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 0, ier_wr = 0, rd_iir = 0, rd_lsr = 0, rd_msr = 0;
  logic [7:0] ier_wdata = 0;
  logic       rx_ready = 0, rx_timeout = 0, rx_par_err = 0, rx_frm_err = 0;
  logic [CW-1:0] rx_count = 0;
  logic [1:0] rx_trig = 0;
  logic       ev_overrun = 0, ev_break = 0, tx_empty = 0, tx_done = 0, thr_wr = 0;
  logic [3:0] ev_msr_delta = 0;
  logic [7:0] ier_value, iir_value;
  logic       irq;
  logic [3:0] line_err, msr_delta;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rx_ready(rx_ready),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .ev_overrun(ev_overrun),
    .ev_break(ev_break), .tx_empty(tx_empty), .tx_done(tx_done), .thr_wr(thr_wr),
    .ev_msr_delta(ev_msr_delta), .ier_value(ier_value), .iir_value(iir_value),
    .irq(irq), .line_err(line_err), .msr_delta(msr_delta)
  );

  // {ier[3:0], fifo, ready, count[4:0], trig[1:0], timeout, par, frm, expected iir[7:0]}
  localparam logic [23:0] TBL [0:NV-1] = '{
    {4'h0, 1'b0, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 1'b0, 8'h01},
    {4'hF, 1'b0, 1'b1, 5'd0,  2'd0, 1'b0, 1'b0, 1'b0, 8'h04},
    {4'hF, 1'b1, 1'b1, 5'd3,  2'd1, 1'b0, 1'b0, 1'b0, 8'hC1},
    {4'hF, 1'b1, 1'b1, 5'd4,  2'd1, 1'b0, 1'b0, 1'b0, 8'hC4},
    {4'hF, 1'b1, 1'b1, 5'd7,  2'd2, 1'b0, 1'b0, 1'b0, 8'hC1},
    {4'hF, 1'b1, 1'b1, 5'd8,  2'd2, 1'b0, 1'b0, 1'b0, 8'hC4},
    {4'hF, 1'b1, 1'b1, 5'd13, 2'd3, 1'b0, 1'b0, 1'b0, 8'hC1},
    {4'hF, 1'b1, 1'b1, 5'd14, 2'd3, 1'b0, 1'b0, 1'b0, 8'hC4},
    {4'hF, 1'b1, 1'b1, 5'd1,  2'd0, 1'b0, 1'b0, 1'b0, 8'hC4},
    {4'hF, 1'b1, 1'b1, 5'd1,  2'd3, 1'b1, 1'b0, 1'b0, 8'hCC},
    {4'hE, 1'b1, 1'b1, 5'd16, 2'd3, 1'b1, 1'b0, 1'b0, 8'hC1},
    {4'hF, 1'b1, 1'b1, 5'd16, 2'd3, 1'b1, 1'b1, 1'b0, 8'hC6},
    {4'hB, 1'b1, 1'b0, 5'd1,  2'd3, 1'b1, 1'b1, 1'b0, 8'hCC},
    {4'h4, 1'b0, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 1'b1, 8'h06},
    {4'h0, 1'b0, 1'b1, 5'd0,  2'd0, 1'b1, 1'b0, 1'b1, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic write_ier(input logic [7:0] v);
    @(negedge clk);
    ier_wdata = v;
    ier_wr = 1'b1;
    @(negedge clk);
    ier_wr = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic quiet();
    rx_ready = 0; rx_timeout = 0; rx_par_err = 0; rx_frm_err = 0;
    rx_count = 0; rx_trig = 0; fifo_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 iir", iir_value, 8'h01);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 ier", ier_value, 8'h00);
    chk("R1 line_err", {4'h0, line_err}, 8'h00);
    chk("R1 msr_delta", {4'h0, msr_delta}, 8'h00);

    // R2 R3 R4 R5: table of level-input patterns
    for (int i = 0; i < NV; i++) begin
      write_ier({4'h0, TBL[i][23:20]});
      @(negedge clk);
      fifo_en    = TBL[i][19];
      rx_ready   = TBL[i][18];
      rx_count   = TBL[i][17:13];
      rx_trig    = TBL[i][12:11];
      rx_timeout = TBL[i][10];
      rx_par_err = TBL[i][9];
      rx_frm_err = TBL[i][8];
      settle();
      chk($sformatf("R2/R3/R4/R5 vector %0d iir", i), iir_value, TBL[i][7:0]);
      chk($sformatf("R6 vector %0d irq", i), {7'h0, irq}, {7'h0, TBL[i][3:0] != 4'h1});
    end
    quiet();

    // R13 / R7: transmitter empty
    write_ier(8'h02);
    pulse(tx_done); settle();
    chk("R13 tx_done sets pending", iir_value, 8'h02);
    pulse(rd_iir); settle();
    chk("R7 iir read clears thre", iir_value, 8'h01);
    pulse(tx_done);
    rx_ready = 1'b1;
    write_ier(8'h03); settle();
    chk("R2 rxdata over thre", iir_value, 8'h04);
    pulse(rd_iir);
    rx_ready = 1'b0; settle();
    chk("R7 read of other code keeps thre", iir_value, 8'h02);
    pulse(thr_wr); settle();
    chk("R13 thr_wr clears thre", iir_value, 8'h01);

    // R8: write with tx_empty high re-arms; upper data bits dropped
    tx_empty = 1'b1;
    write_ier(8'hF2);
    tx_empty = 1'b0;
    settle();
    chk("R8 ier low bits only", ier_value, 8'h02);
    chk("R8 re-arm thre", iir_value, 8'h02);

    // R11: held read select
    @(negedge clk); rd_iir = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 held read first clear", iir_value, 8'h01);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    settle();
    chk("R11 held read does not clear again", iir_value, 8'h02);
    rd_iir = 1'b0;

    // R12: set wins over clear
    @(negedge clk); thr_wr = 1'b1; tx_done = 1'b1;
    @(negedge clk); thr_wr = 1'b0; tx_done = 1'b0;
    settle();
    chk("R12 tx_done beats thr_wr", iir_value, 8'h02);
    pulse(thr_wr); settle();

    // R9: line status
    write_ier(8'h04);
    pulse(ev_overrun); settle();
    chk("R9 overrun flag", {4'h0, line_err}, 8'h01);
    chk("R2 line code", iir_value, 8'h06);
    rx_par_err = 1'b1;
    pulse(rd_lsr); settle();
    chk("R9 lsr read keeps parity", {4'h0, line_err}, 8'h02);
    chk("R9 parity still raises line code", iir_value, 8'h06);
    rx_par_err = 1'b0; settle();
    chk("R9 line code gone", iir_value, 8'h01);
    pulse(ev_break); settle();
    chk("R9 break flag", {4'h0, line_err}, 8'h08);
    @(negedge clk); rd_lsr = 1'b1; ev_overrun = 1'b1;
    @(negedge clk); rd_lsr = 1'b0; ev_overrun = 1'b0;
    settle();
    chk("R12 overrun beats lsr read, break cleared", {4'h0, line_err}, 8'h01);
    pulse(rd_lsr); settle();
    chk("R9 lsr read clears", {4'h0, line_err}, 8'h00);

    // R10: modem change
    write_ier(8'h08);
    @(negedge clk); ev_msr_delta = 4'b0101;
    @(negedge clk); ev_msr_delta = 4'b0000;
    settle();
    chk("R10 deltas captured", {4'h0, msr_delta}, 8'h05);
    chk("R2 modem code", iir_value, 8'h00);
    chk("R6 irq on modem code", {7'h0, irq}, 8'h01);
    pulse(rd_msr); settle();
    chk("R10 msr read clears", {4'h0, msr_delta}, 8'h00);
    chk("R10 code released", iir_value, 8'h01);

    // R6: one-edge latency
    write_ier(8'h01); settle();
    @(negedge clk); rx_ready = 1'b1;
    #0.5;
    chk("R6 before edge", iir_value, 8'h01);
    @(negedge clk);
    chk("R6 after one edge", iir_value, 8'h04);
    chk("R6 irq after one edge", {7'h0, irq}, 8'h01);
    rx_ready = 1'b0;

    // R5: upper bits follow fifo_en
    fifo_en = 1'b1; settle();
    chk("R5 fifo flags set", iir_value, 8'hC1);
    fifo_en = 1'b0; settle();
    chk("R5 fifo flags clear", iir_value, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule